// File: doc/BRIEF.md
# Burst Column Address Wrap Generator

This block turns one burst request into the list of column addresses that a memory read or write burst touches. A request gives a starting column and a burst size of four or eight beats. The block then sends out one column address per accepted beat. All the addresses of a burst lie inside an aligned group of columns whose size equals the burst length. The upper column bits pick the group and stay fixed. The low bits begin at the requested offset, count up by one, and wrap to the bottom of the group when they pass its top.

Addresses leave on a valid/ready stream. `addr_valid_o` stays high from the cycle after an accepted start until the last address has been taken. While `addr_valid_o` is high and `addr_ready_i` is low, the address and `done_o` are held unchanged, and the burst waits. An address counts as delivered on a clock edge where both valid and ready are high. `done_o` is high together with the final address of a burst. The start strobe is a plain control input. It is taken only while no burst is in progress, and the column and mode are captured at that moment. Reads and writes use the same sequence.

Top module: `burst_col_wrap`

## Requirements
- R1: After reset, `addr_valid_o` and `done_o` are low.
- R2: A start taken while idle makes `addr_valid_o` high one cycle later, and the first address equals the column captured at the start.
- R3: With `mode_i`=1 (eight beats), address bits [COL_W-1:3] stay equal to the start column, and bits [2:0] rise by one per accepted beat modulo 8.
- R4: With `mode_i`=0 (four beats), address bits [COL_W-1:2] stay equal to the start column, and bits [1:0] rise by one per accepted beat modulo 4.
- R5: Each start yields exactly burst-length accepted addresses. `addr_valid_o` is low in the cycle after the last one is accepted.
- R6: `done_o` is high exactly while the last address of a burst is valid, and never while `addr_valid_o` is low.
- R7: While `addr_valid_o` is high and `addr_ready_i` is low, the next cycle still has `addr_valid_o` high, with `addr_o` and `done_o` unchanged.
- R8: A start during a burst is ignored. The running sequence is unchanged and no extra burst follows it.
- R9: Changes on `col_i` and `mode_i` after the start has been taken have no effect on the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Burst request strobe; taken only when idle |
| col_i | input | COL_W | Starting column address |
| mode_i | input | 1 | Burst size: 1 = eight beats, 0 = four beats |
| addr_o | output | COL_W | Current column address of the burst |
| addr_valid_o | output | 1 | `addr_o` holds a beat of the burst |
| addr_ready_i | input | 1 | Consumer takes the address on this edge |
| done_o | output | 1 | Current address is the last of the burst |

## Verification
On every cycle, the assertions check the following:
- the hold rule under back-pressure;
- that the upper bits stay fixed while the low field steps by one modulo the burst size;
- that the first beat equals the start column;
- that `done_o` is never seen without `addr_valid_o`;
- that the stream goes quiet right after the final beat.

Other behaviour can be shown only by the bench's directed scenarios, each compared against sequences computed independently:
- the total beat count per start;
- the exact wrapped order from chosen offsets, including the top column group;
- that an ignored start produces no burst afterwards;
- that input changes during a burst have no effect.

// File: rtl/col_wrap_pkg.sv
package col_wrap_pkg;
  // Widest burst is 2**MAX_BEAT_W beats.
  localparam int unsigned MAX_BEAT_W = 3;

  typedef enum logic {
    BURST_4 = 1'b0,
    BURST_8 = 1'b1
  } burst_mode_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import col_wrap_pkg::*;
#(
  parameter int unsigned BEAT_W = MAX_BEAT_W
) (
  input  burst_mode_e       mode,
  output logic [BEAT_W-1:0] low_mask
);
  localparam int unsigned SHORT_W = BEAT_W - 1;

  always_comb begin
    low_mask = '0;
    for (int i = 0; i < int'(BEAT_W); i++) begin
      if (mode == BURST_8) low_mask[i] = 1'b1;
      else if (i < int'(SHORT_W)) low_mask[i] = 1'b1;
    end
  end
endmodule

// File: rtl/col_wrap_addr.sv
module col_wrap_addr #(
  parameter int unsigned COL_W  = 10,
  parameter int unsigned BEAT_W = 3
) (
  input  logic [COL_W-1:0]  base,
  input  logic [BEAT_W-1:0] beat,
  input  logic [BEAT_W-1:0] low_mask,
  output logic [COL_W-1:0]  addr
);
  logic [BEAT_W-1:0] low_sum;

  assign low_sum = base[BEAT_W-1:0] + beat;

  // Bits inside the burst field take the stepped value; bits above are fixed.
  for (genvar g = 0; g < int'(COL_W); g++) begin : g_bit
    if (g < int'(BEAT_W)) begin : g_low
      assign addr[g] = low_mask[g] ? low_sum[g] : base[g];
    end else begin : g_high
      assign addr[g] = base[g];
    end
  end
endmodule

// File: rtl/beat_sequencer.sv
module beat_sequencer #(
  parameter int unsigned BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_start,
  input  logic [BEAT_W-1:0] low_mask,
  input  logic              ready,
  output logic              busy,
  output logic [BEAT_W-1:0] beat,
  output logic              last
);
  logic accept;

  assign last   = busy && (beat == low_mask);
  assign accept = busy && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      beat <= '0;
    end else if (take_start) begin
      busy <= 1'b1;
      beat <= '0;
    end else if (accept) begin
      if (last) begin
        busy <= 1'b0;
        beat <= '0;
      end else begin
        beat <= beat + 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_col_wrap.sv
module burst_col_wrap
  import col_wrap_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             mode_i,
  output logic [COL_W-1:0] addr_o,
  output logic             addr_valid_o,
  input  logic             addr_ready_i,
  output logic             done_o
);
  localparam int unsigned BEAT_W = MAX_BEAT_W;

  logic [COL_W-1:0]  base_q;
  burst_mode_e       mode_q;
  logic [BEAT_W-1:0] low_mask;
  logic [BEAT_W-1:0] beat;
  logic              busy;
  logic              last;
  logic              take_start;

  assign take_start = start_i && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      mode_q <= BURST_4;
    end else if (take_start) begin
      base_q <= col_i;
      mode_q <= burst_mode_e'(mode_i);
    end
  end

  burst_len_decode #(.BEAT_W(BEAT_W)) u_len (
    .mode     (mode_q),
    .low_mask (low_mask)
  );

  beat_sequencer #(.BEAT_W(BEAT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_start (take_start),
    .low_mask   (low_mask),
    .ready      (addr_ready_i),
    .busy       (busy),
    .beat       (beat),
    .last       (last)
  );

  col_wrap_addr #(.COL_W(COL_W), .BEAT_W(BEAT_W)) u_addr (
    .base     (base_q),
    .beat     (beat),
    .low_mask (low_mask),
    .addr     (addr_o)
  );

  assign addr_valid_o = busy;
  assign done_o       = last;
endmodule

// File: rtl/burst_col_wrap_chk.sv
module burst_col_wrap_chk #(
  parameter int unsigned COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] col_i,
  input logic [COL_W-1:0] addr_o,
  input logic             addr_valid_o,
  input logic             addr_ready_i,
  input logic             done_o,
  input logic             mode_q
);
  // R7
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && !addr_ready_i) |=>
      (addr_valid_o && $stable(addr_o) && $stable(done_o)));

  // R2
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !addr_valid_o) |=> (addr_valid_o && addr_o == $past(col_i)));

  // R3
  step_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && addr_ready_i && !done_o && mode_q) |=>
      (addr_valid_o && addr_o[COL_W-1:3] == $past(addr_o[COL_W-1:3])
       && addr_o[2:0] == 3'($past(addr_o[2:0]) + 3'd1)));

  // R4
  step_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && addr_ready_i && !done_o && !mode_q) |=>
      (addr_valid_o && addr_o[COL_W-1:2] == $past(addr_o[COL_W-1:2])
       && addr_o[1:0] == 2'($past(addr_o[1:0]) + 2'd1)));

  // R6
  done_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> addr_valid_o);

  // R5
  quiet_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && addr_ready_i) |=> !addr_valid_o);

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && start_i && !(addr_ready_i && done_o)) |=> addr_valid_o);
endmodule

bind burst_col_wrap burst_col_wrap_chk #(.COL_W(COL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .col_i        (col_i),
  .addr_o       (addr_o),
  .addr_valid_o (addr_valid_o),
  .addr_ready_i (addr_ready_i),
  .done_o       (done_o),
  .mode_q       (mode_q)
);

// File: tb/burst_col_wrap_bench.sv
module burst_col_wrap_bench;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] col_i = '0;
  logic             mode_i = 1'b0;
  logic [COL_W-1:0] addr_o;
  logic             addr_valid_o;
  logic             addr_ready_i = 1'b0;
  logic             done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  burst_col_wrap #(.COL_W(COL_W)) u_burst_col_wrap (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .col_i        (col_i),
    .mode_i       (mode_i),
    .addr_o       (addr_o),
    .addr_valid_o (addr_valid_o),
    .addr_ready_i (addr_ready_i),
    .done_o       (done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One burst; stall=1 toggles ready low on even cycles, meddle=1 disturbs inputs mid-burst.
  task automatic run_burst(input logic [COL_W-1:0] col, input bit long_m,
                           input bit stall, input bit meddle);
    int len = long_m ? 8 : 4;
    int m = len - 1;
    int idx = 0;
    int cyc = 0;
    logic [COL_W-1:0] prev_addr = '0;
    bit prev_done = 1'b0;
    bit prev_stall = 1'b0;
    string rq = long_m ? "R3" : "R4";
    @(negedge clk);
    start_i = 1'b1; col_i = col; mode_i = long_m; addr_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    while (idx < len && cyc < 64) begin
      logic [COL_W-1:0] expa;
      expa = (col & ~COL_W'(m)) | ((col + COL_W'(idx)) & COL_W'(m));
      addr_ready_i = stall ? cyc[0] : 1'b1;
      if (idx == 0 && cyc == 0) check(addr_o == col, "R2 first address", addr_o, col);
      check(addr_valid_o == 1'b1, "R5 valid during burst", addr_valid_o, 1);
      check(addr_o == expa, meddle ? "R9 address unaffected" : rq, addr_o, expa);
      check(done_o == (idx == len - 1), "R6 done with last beat", done_o, idx == len - 1);
      if (prev_stall) begin
        check(addr_o == prev_addr, "R7 address held", addr_o, prev_addr);
        check(done_o == prev_done, "R7 done held", done_o, prev_done);
      end
      if (meddle && cyc == 1) begin
        start_i = 1'b1; col_i = ~col; mode_i = !long_m;  // R8 start while busy
      end
      prev_addr = addr_o; prev_done = done_o; prev_stall = !addr_ready_i;
      if (addr_ready_i) idx++;
      cyc++;
      @(negedge clk);
    end
    start_i = 1'b0; addr_ready_i = 1'b0;
    check(addr_valid_o == 1'b0, "R5 valid low after last beat", addr_valid_o, 0);
    check(done_o == 1'b0, "R6 done low when idle", done_o, 0);
    @(negedge clk);
    check(addr_valid_o == 1'b0, meddle ? "R8 no extra burst" : "R5 stays idle",
          addr_valid_o, 0);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(addr_valid_o == 1'b0, "R1 valid after reset", addr_valid_o, 0);
    check(done_o == 1'b0, "R1 done after reset", done_o, 0);
    rst_n = 1'b1;
  endtask

  task automatic test_long_aligned();     run_burst(10'h000, 1'b1, 1'b0, 1'b0); endtask
  task automatic test_long_mid_block();   run_burst(10'h2C5, 1'b1, 1'b0, 1'b0); endtask
  task automatic test_short_top_group();  run_burst(10'h3FE, 1'b0, 1'b0, 1'b0); endtask
  task automatic test_short_offset3();    run_burst(10'h157, 1'b0, 1'b0, 1'b0); endtask
  task automatic test_long_stalled();     run_burst(10'h0AE, 1'b1, 1'b1, 1'b0); endtask
  task automatic test_short_stalled();    run_burst(10'h201, 1'b0, 1'b1, 1'b0); endtask
  task automatic test_long_meddled();     run_burst(10'h1F3, 1'b1, 1'b0, 1'b1); endtask
  task automatic test_short_meddled();    run_burst(10'h36A, 1'b0, 1'b1, 1'b1); endtask

  initial begin
    test_reset();
    test_long_aligned();
    test_long_mid_block();
    test_short_top_group();
    test_short_offset3();
    test_long_stalled();
    test_short_stalled();
    test_long_meddled();
    test_short_meddled();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule